// File: doc/BRIEF.md
# Serial Link Error Status Block

This block gathers error events from a point-to-point serial I/O link and the bridge behind it, and holds each event in a sticky status flag. The flags sit in four 32-bit registers that software reads and clears through a simple word-addressed register port. Each flag is cleared by writing 1 to it. A six-bit enable field selects which error categories raise the interrupt output. Bits are numbered big-endian: bit n of a register is vector index 31-n.

A chain failure, signalled as a sync flood, cannot be cleared by a write to its flag. Software instead writes 1 to the secondary-bus-reset bit of the bridge register. The block then drives a reset pulse of fixed length to the secondary bus, and the chain-failure flag drops at the end of that pulse. The physical layer and the packet logic sit outside this block and only deliver single-cycle event pulses.

Top module: `serlink_err_status`

## Requirements
- R1: After reset, every status flag and every enable bit is 0. All four registers read 0, `irq` is 0 and `sbr_pulse` is 0.
- R2: Bits are numbered big-endian, so register bit n is `reg_rdata[31-n]`. The read port is combinational: `reg_rdata` shows the word selected by `reg_addr` in the same cycle.
- R3: An event pulse sets its flag at the next clock edge, and the flag stays set until it is cleared. The flag positions are as follows. `ev_crc[0]` sets link-control bit 22 and `ev_crc[1]` sets link-control bit 23. `ev_link_fail` sets link-control bit 27. `ev_eoc`, `ev_rx_ovf` and `ev_proto` set link-error bits 17, 18 and 19. `ev_rsp` sets error-control bit 6 and `ev_sync_flood` sets error-control bit 7. `ev_sec_serr` sets bridge bit 0.
- R4: Writing 1 to a status bit clears that flag at the write edge. Writing 0 to it leaves the flag unchanged.
- R5: An event in the same cycle as a write-1 clear of its flag leaves the flag set.
- R6: Error-control bits 0 to 5 are read/write enables and take their values from every write to that register. Register bits that hold no flag or enable always read 0.
- R7: The category enabled by each error-control bit is as follows. Bit 0 covers the secondary system error and the sync flood. Bit 1 covers both CRC flags and link failure. Bit 2 covers the response error, and bits 3, 4 and 5 cover end-of-chain, overflow and protocol error. `irq` is 1 exactly while some set flag belongs to an enabled category.
- R8: Writing 1 to error-control bit 7 does not clear the sync-flood flag.
- R9: When the timer is idle, writing 1 to bridge bit 9 raises `sbr_pulse` from the next cycle for exactly SBR_CYCLES cycles (16 by default). Bridge bit 9 reads 1 while the pulse is high.
- R10: The sync-flood flag clears at the clock edge that ends the pulse, unless a sync-flood event arrives in that same cycle.
- R11: Writing 1 to bridge bit 9 while the pulse is running neither restarts nor lengthens the pulse.
- R12: The register word addresses are: 0 for error control, 1 for link control, 2 for link error and 3 for bridge control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed word |
| ev_crc | input | CRC_LANES | CRC error event per lane |
| ev_link_fail | input | 1 | Link failure event |
| ev_eoc | input | 1 | End-of-chain error event |
| ev_rx_ovf | input | 1 | Receive buffer overflow event |
| ev_proto | input | 1 | Protocol error event |
| ev_rsp | input | 1 | Response error received event |
| ev_sync_flood | input | 1 | Sync flood (chain failure) event |
| ev_sec_serr | input | 1 | System error on the secondary bus |
| irq | output | 1 | Non-fatal error interrupt |
| sbr_pulse | output | 1 | Secondary bus reset pulse |

## Verification
The bench sweeps all 64 enable values against all 64 category flag patterns. A wrong category mapping or a wrong big-endian bit position would then show up as a stray or missing interrupt. It races an event against a write-1 clear of the same flag, which catches a design that lets the clear win and loses an error. It measures the reset pulse cycle by cycle, including a second request partway through, so a pulse that is one cycle off or that restarts is caught. It also fires a sync flood on the final pulse cycle, which catches a design that drops a chain failure arriving as the reset ends. A write of 1 to the sync-flood bit must not clear it, since only the bus reset may remove a chain failure.

// File: rtl/serlink_err_pkg.sv
package serlink_err_pkg;

   localparam int REG_W  = 32;
   localparam int N_FLAG = 9;
   localparam int N_CAT  = 6;
   localparam int N_REG  = 4;

   typedef enum logic [1:0] {
      RA_ERRCTL  = 2'd0,
      RA_LINKCTL = 2'd1,
      RA_LINKERR = 2'd2,
      RA_BRIDGE  = 2'd3
   } reg_addr_e;

   // flag slots inside the flag vector
   localparam int FI_CRC0  = 0;
   localparam int FI_CRC1  = 1;
   localparam int FI_FAIL  = 2;
   localparam int FI_EOC   = 3;
   localparam int FI_OVF   = 4;
   localparam int FI_PROT  = 5;
   localparam int FI_RSP   = 6;
   localparam int FI_FLOOD = 7;
   localparam int FI_SERR  = 8;

   // big-endian bit number of the reset request in the bridge word
   localparam int SBR_BIT = 9;

   // big-endian bit number n -> vector index
   function automatic int be(input int n);
      return REG_W - 1 - n;
   endfunction

   function automatic logic [1:0] flag_reg(input int f);
      case (f)
         FI_CRC0, FI_CRC1, FI_FAIL: return RA_LINKCTL;
         FI_EOC, FI_OVF, FI_PROT:   return RA_LINKERR;
         FI_RSP, FI_FLOOD:          return RA_ERRCTL;
         default:                   return RA_BRIDGE;
      endcase
   endfunction

   function automatic int flag_pos(input int f);
      case (f)
         FI_CRC0:  return 22;
         FI_CRC1:  return 23;
         FI_FAIL:  return 27;
         FI_EOC:   return 17;
         FI_OVF:   return 18;
         FI_PROT:  return 19;
         FI_RSP:   return 6;
         FI_FLOOD: return 7;
         default:  return 0;
      endcase
   endfunction

   // enable category (error-control bit) owning each flag
   function automatic int flag_cat(input int f);
      case (f)
         FI_SERR, FI_FLOOD:         return 0;
         FI_CRC0, FI_CRC1, FI_FAIL: return 1;
         FI_RSP:                    return 2;
         FI_EOC:                    return 3;
         FI_OVF:                    return 4;
         default:                   return 5;
      endcase
   endfunction

endpackage

// File: rtl/serlink_sticky_flag.sv
module serlink_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);

   // set has priority: an event racing a clear is never lost
   always_ff @(posedge clk) begin
      if (!rst_n) q <= 1'b0;
      else        q <= set | (q & ~clr);
   end

   a_r3_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> q);
   a_r4_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !q);
   a_r4_holds_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
      (q && !clr) |=> q);

endmodule

// File: rtl/serlink_sbr_timer.sv
module serlink_sbr_timer #(
   parameter int CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic pulse,
   output logic done
);

   localparam int CNT_W = $clog2(CYCLES + 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt <= '0;
      else if (cnt != '0)      cnt <= cnt - CNT_W'(1);
      else if (start)          cnt <= CNT_W'(CYCLES);
   end

   assign pulse = (cnt != '0);
   assign done  = (cnt == CNT_W'(1));

   a_r9_load_on_request: assert property (@(posedge clk) disable iff (!rst_n)
      (!pulse && start) |=> (cnt == CNT_W'(CYCLES)));
   a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse && start) |=> (cnt == $past(cnt) - CNT_W'(1)));
   a_r9_done_inside_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !pulse);

endmodule

// File: rtl/serlink_irq_merge.sv
module serlink_irq_merge
   import serlink_err_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_FLAG-1:0] flags,
   input  logic [N_CAT-1:0]  en,
   output logic              irq
);

   logic [N_CAT-1:0] cat;

   always_comb begin
      cat = '0;
      for (int f = 0; f < N_FLAG; f++) begin
         cat[flag_cat(f)] = cat[flag_cat(f)] | flags[f];
      end
   end

   assign irq = |(cat & en);

   a_r7_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (en != '0));
   a_r7_quiet_without_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (flags == '0) |-> !irq);

endmodule

// File: rtl/serlink_err_status.sv
module serlink_err_status
   import serlink_err_pkg::*;
#(
   parameter int CRC_LANES  = 2,
   parameter int SBR_CYCLES = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           reg_addr,
   input  logic                 reg_wr,
   input  logic [REG_W-1:0]     reg_wdata,
   output logic [REG_W-1:0]     reg_rdata,
   input  logic [CRC_LANES-1:0] ev_crc,
   input  logic                 ev_link_fail,
   input  logic                 ev_eoc,
   input  logic                 ev_rx_ovf,
   input  logic                 ev_proto,
   input  logic                 ev_rsp,
   input  logic                 ev_sync_flood,
   input  logic                 ev_sec_serr,
   output logic                 irq,
   output logic                 sbr_pulse
);

   if (CRC_LANES < 1 || CRC_LANES > 2) begin : g_bad_lanes
      $error("CRC_LANES must be 1 or 2");
   end
   if (SBR_CYCLES < 2) begin : g_bad_sbr
      $error("SBR_CYCLES must be at least 2");
   end

   logic [N_REG-1:0]  wr_hit;
   logic [N_FLAG-1:0] ev_vec;
   logic [N_FLAG-1:0] flag;
   logic [N_CAT-1:0]  en_q;
   logic [N_CAT-1:0]  en_d;
   logic              sbr_start;
   logic              sbr_done;
   logic [REG_W-1:0]  word [N_REG];
   logic              unused_wdata;

   assign unused_wdata = ^reg_wdata;

   always_comb begin
      for (int r = 0; r < N_REG; r++) begin
         wr_hit[r] = reg_wr && (reg_addr == r[1:0]);
      end
   end

   // event vector in flag-slot order
   assign ev_vec[FI_CRC0]  = ev_crc[0];
   assign ev_vec[FI_FAIL]  = ev_link_fail;
   assign ev_vec[FI_EOC]   = ev_eoc;
   assign ev_vec[FI_OVF]   = ev_rx_ovf;
   assign ev_vec[FI_PROT]  = ev_proto;
   assign ev_vec[FI_RSP]   = ev_rsp;
   assign ev_vec[FI_FLOOD] = ev_sync_flood;
   assign ev_vec[FI_SERR]  = ev_sec_serr;

   if (CRC_LANES == 2) begin : g_two_lanes
      assign ev_vec[FI_CRC1] = ev_crc[CRC_LANES-1];
   end else begin : g_one_lane
      assign ev_vec[FI_CRC1] = 1'b0;
   end

   for (genvar f = 0; f < N_FLAG; f++) begin : g_flag
      logic clr_w;
      if (f == FI_FLOOD) begin : g_bus_reset_clear
         // chain failure leaves only through the secondary bus reset
         assign clr_w = sbr_done;
      end else begin : g_w1c_clear
         assign clr_w = wr_hit[flag_reg(f)] && reg_wdata[be(flag_pos(f))];
      end
      serlink_sticky_flag i_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .set   (ev_vec[f]),
         .clr   (clr_w),
         .q     (flag[f])
      );
   end

   always_comb begin
      for (int k = 0; k < N_CAT; k++) begin
         en_d[k] = wr_hit[RA_ERRCTL] ? reg_wdata[be(k)] : en_q[k];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) en_q <= '0;
      else        en_q <= en_d;
   end

   assign sbr_start = wr_hit[RA_BRIDGE] && reg_wdata[be(SBR_BIT)];

   serlink_sbr_timer #(.CYCLES(SBR_CYCLES)) i_sbr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (sbr_start),
      .pulse (sbr_pulse),
      .done  (sbr_done)
   );

   serlink_irq_merge i_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .flags (flag),
      .en    (en_q),
      .irq   (irq)
   );

   always_comb begin
      for (int r = 0; r < N_REG; r++) word[r] = '0;
      for (int f = 0; f < N_FLAG; f++) begin
         word[flag_reg(f)][be(flag_pos(f))] = flag[f];
      end
      for (int k = 0; k < N_CAT; k++) begin
         word[RA_ERRCTL][be(k)] = en_q[k];
      end
      word[RA_BRIDGE][be(SBR_BIT)] = sbr_pulse;
   end

   assign reg_rdata = word[reg_addr];

   a_r8_flood_survives_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit[RA_ERRCTL] && reg_wdata[be(7)] && flag[FI_FLOOD] && !sbr_done)
      |=> flag[FI_FLOOD]);
   a_r10_flood_clears_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      (sbr_done && !ev_sync_flood) |=> !flag[FI_FLOOD]);
   a_r9_readback_tracks_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == RA_BRIDGE) |-> (reg_rdata[be(SBR_BIT)] == sbr_pulse));

endmodule

// File: tb/test_serlink_err_status.sv
`timescale 1ns/1ps
module test_serlink_err_status;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [1:0]  ev_crc = '0;
   logic        ev_link_fail = 0, ev_eoc = 0, ev_rx_ovf = 0, ev_proto = 0;
   logic        ev_rsp = 0, ev_sync_flood = 0, ev_sec_serr = 0;
   logic        irq, sbr_pulse;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   serlink_err_status i_serlink_err_status (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_crc(ev_crc),
      .ev_link_fail(ev_link_fail), .ev_eoc(ev_eoc), .ev_rx_ovf(ev_rx_ovf),
      .ev_proto(ev_proto), .ev_rsp(ev_rsp), .ev_sync_flood(ev_sync_flood),
      .ev_sec_serr(ev_sec_serr), .irq(irq), .sbr_pulse(sbr_pulse));

   // bench-side map, event slot order: crc0 crc1 fail eoc ovf prot rsp flood serr
   function automatic logic [31:0] bb(input int n);
      return 32'h1 << (31 - n);
   endfunction
   function automatic logic [1:0] tb_reg(input int f);
      int r [9] = '{1, 1, 1, 2, 2, 2, 0, 0, 3};
      return 2'(r[f]);
   endfunction
   function automatic int tb_bit(input int f);
      int b [9] = '{22, 23, 27, 17, 18, 19, 6, 7, 0};
      return b[f];
   endfunction
   function automatic logic [31:0] enw(input logic [5:0] e);
      logic [31:0] w = '0;
      for (int k = 0; k < 6; k++) if (e[k]) w |= bb(k);
      return w;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b0;
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(posedge clk);
      #1 reg_wr = 1'b0;
   endtask

   task automatic drive_ev(input logic [8:0] m);
      ev_crc = m[1:0]; ev_link_fail = m[2]; ev_eoc = m[3]; ev_rx_ovf = m[4];
      ev_proto = m[5]; ev_rsp = m[6]; ev_sync_flood = m[7]; ev_sec_serr = m[8];
   endtask

   task automatic fire(input logic [8:0] m);
      @(negedge clk);
      drive_ev(m);
      @(posedge clk);
      #1 drive_ev('0);
   endtask

   task automatic clear_all();
      wr(0, bb(6));
      wr(1, 32'hFFFF_FFFF);
      wr(2, 32'hFFFF_FFFF);
      wr(3, bb(0));
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int cnt;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      for (int r = 0; r < 4; r++) begin
         rd(2'(r), d);
         check("R1 reset read", d, 0);
      end
      check("R1 irq after reset", {31'b0, irq}, 0);
      check("R1 pulse after reset", {31'b0, sbr_pulse}, 0);

      // R2 R3 R4 R12 per-flag set, write-0 hold, write-1 clear
      for (int f = 0; f < 9; f++) begin
         if (f == 7) continue;
         fire(9'(1 << f));
         rd(tb_reg(f), d);
         check("R3 R2 R12 flag set", d, bb(tb_bit(f)));
         wr(tb_reg(f), 32'h0);
         rd(tb_reg(f), d);
         check("R4 write 0 holds", d, bb(tb_bit(f)));
         wr(tb_reg(f), bb(tb_bit(f)));
         rd(tb_reg(f), d);
         check("R4 write 1 clears", d, 0);
      end

      // R5 event against clear in the same cycle
      @(negedge clk);
      ev_eoc = 1'b1; reg_addr = 2; reg_wdata = bb(17); reg_wr = 1'b1;
      @(posedge clk);
      #1 begin ev_eoc = 1'b0; reg_wr = 1'b0; end
      rd(2, d);
      check("R5 event wins over clear", d, bb(17));
      wr(2, bb(17));

      // R6 enables readback and empty bits
      wr(0, 32'hFFFF_FFFF);
      rd(0, d);
      check("R6 enables only", d, enw(6'h3F));
      wr(1, 32'hFFFF_FFFF);
      rd(1, d);
      check("R6 empty link control", d, 0);
      wr(0, 32'h0);
      rd(0, d);
      check("R6 enables cleared", d, 0);

      // R7 sweep: category pattern x enable value
      for (int p = 0; p < 64; p++) begin
         logic [8:0] m;
         m = '0;
         m[8] = p[0]; m[0] = p[1]; m[6] = p[2]; m[3] = p[3]; m[4] = p[4]; m[5] = p[5];
         fire(m);
         for (int e = 0; e < 64; e++) begin
            wr(0, enw(6'(e)));
            check("R7 irq sweep", {31'b0, irq}, {31'b0, |(6'(p) & 6'(e))});
         end
         rd(0, d);
         check("R6 R7 control readback", d, enw(6'h3F) | (p[2] ? bb(6) : 32'h0));
         clear_all();
      end

      // R7 other crc lane and link failure under the crc enable
      fire(9'b000000010);
      wr(0, enw(6'b000010));
      check("R7 crc lane 1 irq", {31'b0, irq}, 1);
      clear_all();
      fire(9'b000000100);
      wr(0, enw(6'b111101));
      check("R7 link fail other enables", {31'b0, irq}, 0);
      wr(0, enw(6'b000010));
      check("R7 link fail crc enable", {31'b0, irq}, 1);
      clear_all();

      // R8 sync flood not cleared by write 1
      fire(9'b010000000);
      wr(0, bb(0));
      check("R7 flood under serr enable", {31'b0, irq}, 1);
      wr(0, bb(0) | bb(7));
      rd(0, d);
      check("R8 flood survives write 1", d, bb(0) | bb(7));

      // R9 R11 pulse length, readback, request mid-pulse
      wr(3, bb(9));
      cnt = 0;
      while (sbr_pulse && cnt < 100) begin
         cnt++;
         check("R9 bit 9 reads 1 in pulse", reg_rdata & bb(9), bb(9));
         if (cnt == 5) begin reg_wdata = bb(9); reg_wr = 1'b1; end
         @(posedge clk);
         #1 reg_wr = 1'b0;
      end
      check("R9 R11 pulse length", 32'(cnt), 16);
      rd(0, d);
      check("R10 flood cleared at end", d, bb(0));
      check("R10 irq drops", {31'b0, irq}, 0);
      rd(3, d);
      check("R9 bit 9 after pulse", d, 0);

      // R10 flood event on the last pulse cycle
      fire(9'b010000000);
      wr(3, bb(9));
      cnt = 0;
      while (sbr_pulse && cnt < 100) begin
         cnt++;
         if (cnt == 16) ev_sync_flood = 1'b1;
         @(posedge clk);
         #1 ev_sync_flood = 1'b0;
      end
      check("R9 second pulse length", 32'(cnt), 16);
      rd(0, d);
      check("R10 late flood kept", d, bb(0) | bb(7));

      done = 1;
      summary();
      $finish;
   end

endmodule